// File: doc/BRIEF.md
# Event Status Reporting Register Unit

This block gathers event pulses from an instrument into three sticky 8-bit event registers and reduces them into a status byte. The first register carries standard events. The second carries measurement-sequence events, and the third carries comparator results. Each event register has a host-writable enable mask. The masked value is OR-reduced into one summary bit, and each summary bit lands on a fixed position of the status byte.

A simple register-access port lets a host write the enable masks and read all six registers. Reading an event register returns its contents and empties it. A separate clear-all strobe empties all three event registers at once and leaves the masks alone.

A two-state power-up sequencer sets the power-on flag once after reset. The sequencer leaves reset in `ST_POWERUP`. It takes transition `T_BOOT` to `ST_ACTIVE` on the first clock edge, and it injects the power-on event on that same edge. It then stays in `ST_ACTIVE` through transition `T_HOLD` until the next reset.

Top module: `evt_status_unit`

## Requirements
- R1: While reset is held, the status byte and `rd_valid` are 0, and all enable masks reset to 0. On the first clock edge after reset is released, bit 7 (power-on) of the standard event register is set.
- R2: Every event bit is sticky. A one-cycle input pulse sets the bit, and the bit stays set until a read of that register, a clear-all or a reset.
- R3: In device register 0, `meas_fault` sets bit 5, `meas_done` sets bit 1 and `conv_done` sets bit 0. Bits 7, 6, 4, 3 and 2 always read as 0.
- R4: In device register 1, `volt_cmp[2:0]` (high, in-range, low) set bits 5, 4 and 3. `res_cmp[2:0]` (high, in-range, low) set bits 2, 1 and 0. Bits 7 and 6 always read as 0.
- R5: Bit n of `std_evt_pulse` sets bit n of the standard event register, for n from 7 down to 0. The bits are, from 7 down to 0: power-on, user request, command error, execution error, device-dependent error, query error, request control, operation complete.
- R6: The status byte is computed combinationally from the registered state. Bit 5 is the OR of (standard events AND standard enable). Bit 0 is the same for device register 0, and bit 1 is the same for device register 1. Bits 7, 6, 4, 3 and 2 are 0. A summary bit follows an enable write on the same edge that the write takes effect.
- R7: A write takes effect on the clock edge at which it is presented. Enable masks hold all 8 written bits, and reading an enable mask leaves it unchanged.
- R8: A read of an event register returns the value it held before the read edge, and the register is 0 after that edge.
- R9: A `clr_all` pulse empties all three event registers and leaves all enable masks unchanged.
- R10: If an event and a clear (either a read or `clr_all`) arrive in the same cycle, the event bit is set after that edge.
- R11: Writes to event register addresses change nothing. Addresses 6 and 7 read as 0 and ignore writes.
- R12: Address map: 0 is the standard events, 1 the standard enable, 2 device 0 events, 3 device 0 enable, 4 device 1 events and 5 device 1 enable. A read request (`acc_valid`=1, `acc_write`=0) raises `rd_valid` for exactly one cycle after the edge that takes the request, and `rd_data` holds the read value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| std_evt_pulse | input | 8 | Standard event set pulses, one per bit |
| meas_fault | input | 1 | Measurement fault pulse |
| meas_done | input | 1 | End-of-measurement pulse |
| conv_done | input | 1 | End-of-conversion pulse |
| volt_cmp | input | 3 | Voltage comparator pulses {high, in-range, low} |
| res_cmp | input | 3 | Resistance comparator pulses {high, in-range, low} |
| acc_valid | input | 1 | Host access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 8 | Write data |
| clr_all | input | 1 | Clear all event registers |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| status_byte | output | 8 | Summary status byte |

## Verification
The collisions that matter are an event pulse landing in the same cycle as the destructive read of its register, and an event pulse landing together with `clr_all`. The directed steps stage both collisions explicitly. The bench then checks that the read returns only the older contents and that a follow-up read still shows the new bit. A seeded random phase also drives sparse events, random reads and writes, and occasional `clr_all` together in the same cycles. Each read result and the status byte in every cycle are compared against a bench model in which the clears act first and the new events are ORed in after them.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;

    localparam int EVT_W     = 8;
    localparam int N_CHAN    = 3;

    // channel indices
    localparam int CH_STD    = 0;
    localparam int CH_DEV0   = 1;
    localparam int CH_DEV1   = 2;

    // bit positions that other logic decodes
    localparam int PON_BIT   = 7;
    localparam int FAULT_BIT = 5;
    localparam int MDONE_BIT = 1;
    localparam int CDONE_BIT = 0;
    localparam int VOLT_LSB  = 3;
    localparam int RES_LSB   = 0;

    typedef enum logic [0:0] {
        ST_POWERUP = 1'b0,
        ST_ACTIVE  = 1'b1
    } boot_state_e;

    // bits that a channel can ever hold
    function automatic logic [EVT_W-1:0] chan_mask(input int ch);
        logic [EVT_W-1:0] m;
        m = '0;
        case (ch)
            CH_STD:  m = '1;
            CH_DEV0: begin
                m[FAULT_BIT] = 1'b1;
                m[MDONE_BIT] = 1'b1;
                m[CDONE_BIT] = 1'b1;
            end
            CH_DEV1: m[VOLT_LSB+2:RES_LSB] = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

    // status byte position of each channel summary
    function automatic int sb_pos(input int ch);
        case (ch)
            CH_STD:  return 5;
            CH_DEV0: return 0;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_r;
    logic [W-1:0] set_m;

    assign set_m = set_i & KEEP;

    // clear first, then new events on top: an event beside a clear survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= (clr_i ? '0 : q_r) | set_m;
    end

    assign q_o = q_r;

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));

    p_evt_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m != '0) |=> ((q_o & $past(set_m)) == $past(set_m)));

    p_clr_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_m == '0) |=> (q_o == '0));

endmodule

// File: rtl/evt_summary.sv
module evt_summary #(
    parameter int W = 8
) (
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] en_i,
    output logic         hit_o
);

    assign hit_o = |(evt_i & en_i);

endmodule

// File: rtl/evt_status_unit.sv
module evt_status_unit
    import evt_status_pkg::*;
#(
    parameter int DW     = EVT_W,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     std_evt_pulse,
    input  logic              meas_fault,
    input  logic              meas_done,
    input  logic              conv_done,
    input  logic [2:0]        volt_cmp,
    input  logic [2:0]        res_cmp,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DW-1:0]     acc_wdata,
    input  logic              clr_all,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic [7:0]        status_byte
);

    localparam int NCH = N_CHAN;

    boot_state_e state, state_nx;
    logic        pon_fire;
    logic        rd_req, wr_req;
    logic [DW-1:0] ev_set [NCH];
    logic [DW-1:0] ev_q   [NCH];
    logic [DW-1:0] ev_en  [NCH];
    logic          ev_clr [NCH];
    logic [NCH-1:0] ev_hit;
    logic [DW-1:0] rd_mux;

    assign rd_req = acc_valid && !acc_write;
    assign wr_req = acc_valid &&  acc_write;

    // power-up sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_POWERUP;
        else        state <= state_nx;
    end

    // power-up sequencer: next state and outputs
    always_comb begin
        state_nx = state;
        pon_fire = 1'b0;
        unique case (state)
            ST_POWERUP: begin
                pon_fire = 1'b1;
                state_nx = ST_ACTIVE;    // T_BOOT
            end
            ST_ACTIVE: begin
                state_nx = ST_ACTIVE;    // T_HOLD
            end
            default: state_nx = ST_ACTIVE;
        endcase
    end

    // event sources per channel
    always_comb begin
        ev_set[CH_STD] = std_evt_pulse;
        if (pon_fire) ev_set[CH_STD][PON_BIT] = 1'b1;

        ev_set[CH_DEV0]            = '0;
        ev_set[CH_DEV0][FAULT_BIT] = meas_fault;
        ev_set[CH_DEV0][MDONE_BIT] = meas_done;
        ev_set[CH_DEV0][CDONE_BIT] = conv_done;

        ev_set[CH_DEV1]                    = '0;
        ev_set[CH_DEV1][VOLT_LSB+2:VOLT_LSB] = volt_cmp;
        ev_set[CH_DEV1][RES_LSB+2:RES_LSB]   = res_cmp;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [DW-1:0] KM = chan_mask(g);
        localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(2 * g + 1);

        assign ev_clr[g] = clr_all || (rd_req && acc_addr == A_EVT);

        evt_latch #(.W(DW), .KEEP(KM)) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ev_set[g]),
            .clr_i (ev_clr[g]),
            .q_o   (ev_q[g])
        );

        evt_summary #(.W(DW)) u_sum (
            .evt_i (ev_q[g]),
            .en_i  (ev_en[g]),
            .hit_o (ev_hit[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          ev_en[g] <= '0;
            else if (wr_req && acc_addr == A_EN) ev_en[g] <= acc_wdata;
        end

        p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_req && acc_addr == A_EN) |=> $stable(ev_en[g]));
    end

    // read selection
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NCH; c++) begin
            if (acc_addr == ADDR_W'(2 * c))     rd_mux = ev_q[c];
            if (acc_addr == ADDR_W'(2 * c + 1)) rd_mux = ev_en[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= rd_mux;
        end
    end

    // status byte assembly
    always_comb begin
        status_byte = '0;
        for (int c = 0; c < NCH; c++) status_byte[sb_pos(c)] = ev_hit[c];
    end

    p_boot_pon_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POWERUP) |=> ev_q[CH_STD][PON_BIT]);

    p_rd_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

endmodule

// File: tb/test_evt_status_unit.sv
`timescale 1ns/1ps
module test_evt_status_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] std_evt_pulse = '0;
    logic       meas_fault = 0, meas_done = 0, conv_done = 0;
    logic [2:0] volt_cmp = '0, res_cmp = '0;
    logic       acc_valid = 0, acc_write = 0;
    logic [2:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic       clr_all = 0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [7:0] status_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_q  [3];
    logic [7:0] m_en [3];
    bit         m_boot;

    always #5 clk = ~clk;

    evt_status_unit i_evt_status_unit (
        .clk(clk), .rst_n(rst_n), .std_evt_pulse(std_evt_pulse),
        .meas_fault(meas_fault), .meas_done(meas_done), .conv_done(conv_done),
        .volt_cmp(volt_cmp), .res_cmp(res_cmp),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .clr_all(clr_all),
        .rd_valid(rd_valid), .rd_data(rd_data), .status_byte(status_byte)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s = '0;
        s[5] = |(m_q[0] & m_en[0]);
        s[0] = |(m_q[1] & m_en[1]);
        s[1] = |(m_q[2] & m_en[2]);
        return s;
    endfunction

    function automatic logic [7:0] model_read(input logic [2:0] a);
        if (a >= 3'd6) return 8'h00;
        return a[0] ? m_en[a[2:1]] : m_q[a[2:1]];
    endfunction

    // one cycle: drive at negedge, update model, check at next negedge
    task automatic cyc(input string tag, input logic [7:0] sp, input logic [2:0] d0,
                       input logic [2:0] vc, input logic [2:0] rc,
                       input bit av, input bit aw, input logic [2:0] ad,
                       input logic [7:0] wd, input bit ca);
        logic [7:0] s [3];
        logic [7:0] erd;
        bit erv;
        std_evt_pulse = sp;
        {meas_fault, meas_done, conv_done} = d0;
        volt_cmp = vc; res_cmp = rc;
        acc_valid = av; acc_write = aw; acc_addr = ad; acc_wdata = wd;
        clr_all = ca;
        s[0] = sp | (m_boot ? 8'h80 : 8'h00);
        s[1] = {2'b00, d0[2], 3'b000, d0[1], d0[0]};
        s[2] = {2'b00, vc, rc};
        erv = av && !aw;
        erd = erv ? model_read(ad) : 8'h00;
        for (int c = 0; c < 3; c++) begin
            bit cl;
            cl = ca || (erv && ad == 3'(2 * c));
            m_q[c] = (cl ? 8'h00 : m_q[c]) | s[c];
        end
        if (av && aw && ad[0] && ad < 3'd6) m_en[ad[2:1]] = wd;
        m_boot = 0;
        @(negedge clk);
        chk("R12 rd_valid", {7'b0, rd_valid}, {7'b0, erv});
        if (erv) chk(tag, rd_data, erd);
        chk("R6 status", status_byte, exp_status());
    endtask

    task automatic idle(); cyc("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic rd(input logic [2:0] a, input string tag);
        cyc(tag, 0, 0, 0, 0, 1, 0, a, 0, 0);
    endtask
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc("R7", 0, 0, 0, 0, 1, 1, a, d, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 3; c++) begin m_q[c] = 0; m_en[c] = 0; end
        repeat (3) @(negedge clk);
        chk("R1 status in reset", status_byte, 8'h00);
        chk("R1 rd_valid in reset", {7'b0, rd_valid}, 8'h00);
        rst_n = 1'b1;
        m_boot = 1;
        idle();
        rd(3'd0, "R1 power-on bit");
        rd(3'd1, "R1 std enable zero");
        rd(3'd3, "R1 dev0 enable zero");
        rd(3'd5, "R1 dev1 enable zero");

        // R5 standard event mapping
        cyc("R5", 8'h41, 0, 0, 0, 0, 0, 0, 0, 0);
        rd(3'd0, "R5 std bits");
        cyc("R5", 8'hBE, 0, 0, 0, 0, 0, 0, 0, 0);
        rd(3'd0, "R5 std bits upper");

        // R3 device 0 layout, R11 write to event address ignored
        cyc("R3", 0, 3'b111, 0, 0, 0, 0, 0, 0, 0);
        wr(3'd2, 8'hFF);
        rd(3'd2, "R3 dev0 layout with R11 ignored write");
        cyc("R3", 0, 3'b010, 0, 0, 0, 0, 0, 0, 0);
        rd(3'd2, "R3 dev0 done bit");

        // R4 device 1 layout
        cyc("R4", 0, 0, 3'b101, 3'b010, 0, 0, 0, 0, 0);
        rd(3'd4, "R4 dev1 pattern A");
        cyc("R4", 0, 0, 3'b010, 3'b101, 0, 0, 0, 0, 0);
        rd(3'd4, "R4 dev1 pattern B");

        // R2 stickiness over idle cycles
        cyc("R2", 8'h04, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (5) idle();
        rd(3'd0, "R2 sticky bit");
        rd(3'd0, "R8 empty after read");

        // R6 summaries and R7 enables
        wr(3'd1, 8'h20);
        cyc("R6", 8'h20, 0, 0, 0, 0, 0, 0, 0, 0);
        wr(3'd3, 8'h01);
        cyc("R6", 0, 3'b001, 0, 0, 0, 0, 0, 0, 0);
        wr(3'd5, 8'h04);
        cyc("R6", 0, 0, 0, 3'b100, 0, 0, 0, 0, 0);
        chk("R6 all three summaries", status_byte, 8'h23);
        wr(3'd1, 8'h00);
        chk("R6 mask drop", status_byte, 8'h03);
        rd(3'd3, "R7 enable readback");
        rd(3'd3, "R7 enable read unchanged");

        // R9 clear-all keeps enables
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R9 status cleared", status_byte, 8'h00);
        rd(3'd0, "R9 std empty");
        rd(3'd2, "R9 dev0 empty");
        rd(3'd4, "R9 dev1 empty");
        rd(3'd5, "R9 enable kept");

        // R10 event beside clears
        cyc("R10", 8'h08, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R10 read returns older value", 8'h01, 0, 0, 0, 1, 0, 3'd0, 0, 0);
        rd(3'd0, "R10 event beside read kept");
        cyc("R10", 0, 0, 3'b100, 0, 0, 0, 0, 0, 1);
        rd(3'd4, "R10 event beside clr_all kept");

        // R11 unused addresses
        wr(3'd6, 8'hAA);
        wr(3'd7, 8'h55);
        rd(3'd6, "R11 addr6 zero");
        rd(3'd7, "R11 addr7 zero");

        // random phase
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] sp;
            logic [2:0] d0, vc, rc, ad;
            bit av, aw, ca;
            sp = (($urandom % 4) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            d0 = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
            vc = (($urandom % 5) == 0) ? 3'($urandom) : 3'b000;
            rc = (($urandom % 5) == 0) ? 3'($urandom) : 3'b000;
            av = ($urandom % 2) == 1;
            aw = ($urandom % 3) == 0;
            ad = 3'($urandom);
            ca = ($urandom % 16) == 0;
            cyc("R8 random read", sp, d0, vc, rc, av, aw, ad, 8'($urandom), ca);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule